// File: doc/BRIEF.md
# DMA Channel Request Detector

This block is the per-channel front end of a DMA controller. It decides when its channel has a transfer request waiting and raises a single request flag towards the transfer engine. The engine answers with a one-cycle service acknowledge, which retires the request.

A request can come from one of two sources. In the software-started source, setting the channel's start bit is itself the request. In the line-driven source, the start bit only arms the channel. Requests then come from an asynchronous request line driven by the interrupt controller. The line is resynchronised, and it can be sensed as a high level, a low level, a rising edge or a falling edge.

The interrupt controller's line is active low, so that source is normally configured for low-level sensing. Clearing the start bit disarms the channel at once and throws away any request that has not been serviced.

Top module: `dma_req_detect`

## Requirements
- R1: With `src_ext_i`=0, a 0-to-1 change of `arm_i` makes `req_o` high after the next rising clock edge.
- R2: With `src_ext_i`=1, the request line has no effect while `arm_i`=0, and an edge seen while disarmed is not remembered after arming.
- R3: The request line passes through a two-flop synchroniser, so a change on it shows on `req_o` after the third rising clock edge and not earlier.
- R4: Level sensing (`sense_mode_i`=00 for low, 01 for high) requests while the synchronised line sits at the selected level. After an acknowledge the request rises again if that level is still present, and stays low if it is not.
- R5: Edge sensing (`sense_mode_i`=10 for falling, 11 for rising) turns one selected edge into exactly one request. The opposite edge is ignored, and a line that stays put brings no further request after the acknowledge.
- R6: Clearing `arm_i` drops `req_o` in the same cycle and discards the pending request, which does not come back when the channel is re-armed.
- R7: Reset (synchronous, active low) clears `req_o` and preloads the synchroniser with the line's idle level, so arming straight after reset gives no spurious request.
- R8: Once raised, `req_o` stays high while the channel is armed until `ack_i` is sampled high.
- R9: With `src_ext_i`=0, the request line has no effect on `req_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arm_i | input | 1 | Channel start bit from the control register |
| src_ext_i | input | 1 | Request source: 0 software start, 1 external line |
| sense_mode_i | input | 2 | Line sensing: 00 low level, 01 high level, 10 falling edge, 11 rising edge |
| ext_line_i | input | 1 | Asynchronous request line from the interrupt controller |
| ack_i | input | 1 | Service acknowledge from the transfer engine |
| req_o | output | 1 | Pending transfer request |

## Verification
The properties assume three things about the inputs:
- the source select and sensing mode change only while the channel is disarmed;
- the acknowledge arrives only as a single-cycle pulse while a request is showing;
- every level the line takes lasts at least two clock cycles, so the synchroniser never drops it.

The directed stimulus reconfigures the channel only after clearing `arm_i`, pulses `ack_i` for exactly one cycle with `req_o` high, and changes the line on falling clock edges with every level held for two cycles or longer.

// File: rtl/dma_req_pkg.sv
// Package: shared encodings for the DMA channel request detector.
// Assumes: the sensing-mode field is two bits wide; bit 1 selects edge sensing.
package dma_req_pkg;

    // Line sensing encoding as seen on sense_mode_i.
    typedef enum logic [1:0] {
        SENSE_LOW_LVL   = 2'b00,
        SENSE_HIGH_LVL  = 2'b01,
        SENSE_FALL_EDGE = 2'b10,
        SENSE_RISE_EDGE = 2'b11
    } sense_mode_e;

    // True when the mode reacts to transitions rather than levels.
    function automatic logic mode_is_edge(input sense_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/req_line_sync.sv
// Module: req_line_sync
// Brings the asynchronous request line into the clock domain through STAGES
// flops, and keeps one extra flop holding the previous synchronised value for
// edge detection.
// Assumes: each level on line_i lasts longer than one clock period.
module req_line_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s_o,
    output logic line_prev_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] pipe_q;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Stage 0: capture the raw line.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe_q[g] <= IDLE;
                    else        pipe_q[g] <= line_i;
                end
            end else begin : g_next
                // Later stages: shift the sample one flop onwards.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe_q[g] <= IDLE;
                    else        pipe_q[g] <= pipe_q[g-1];
                end
            end
        end
    endgenerate

    assign line_s_o    = pipe_q[STAGES-1];
    assign line_prev_o = pipe_q[STAGES];

endmodule

// File: rtl/req_trigger_eval.sv
// Module: req_trigger_eval
// Combinational: decides whether a new request event occurs this cycle,
// from the source select, the sensing mode and the start-bit rise.
// Assumes: the mode and source stay stable while the channel is armed.
module req_trigger_eval
    import dma_req_pkg::*;
(
    input  logic        arm_i,
    input  logic        arm_rise_i,
    input  logic        src_ext_i,
    input  sense_mode_e mode_i,
    input  logic        line_s_i,
    input  logic        line_prev_i,
    output logic        trig_o
);
    logic lvl_hit;
    logic edge_hit;

    // Level match against the selected polarity (mode bit 0 = active level).
    always_comb lvl_hit = (line_s_i == mode_i[0]);

    // Edge match: the line moved into the level named by mode bit 0.
    always_comb edge_hit = (line_s_i == mode_i[0]) && (line_prev_i != mode_i[0]);

    // Select the event source; nothing is raised while disarmed.
    always_comb begin
        if (!arm_i)              trig_o = 1'b0;
        else if (!src_ext_i)     trig_o = arm_rise_i;
        else if (mode_is_edge(mode_i)) trig_o = edge_hit;
        else                     trig_o = lvl_hit;
    end

endmodule

// File: rtl/req_pending.sv
// Module: req_pending
// Holds the pending request flag: set by a trigger, cleared by the
// acknowledge, flushed whenever the channel is disarmed.
// Assumes: ack_i is only pulsed while the request is visible.
module req_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic trig_i,
    input  logic ack_i,
    output logic pend_o
);
    logic pend_q;

    // Pending flag update; a trigger in the ack cycle re-raises it.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= arm_i & ((pend_q & ~ack_i) | trig_i);
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/dma_req_detect.sv
// Module: dma_req_detect (top)
// Per-channel DMA request detector. Combines a software start bit with a
// resynchronised external request line sensed by level or edge, and presents
// one request flag retired by the engine's acknowledge.
// Assumes: configuration changes only while arm_i is low.
module dma_req_detect
    import dma_req_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter logic LINE_IDLE   = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_i,
    input  logic       src_ext_i,
    input  logic [1:0] sense_mode_i,
    input  logic       ext_line_i,
    input  logic       ack_i,
    output logic       req_o
);
    logic        arm_q;
    logic        arm_rise;
    logic        line_s;
    logic        line_prev;
    logic        trig;
    logic        pend;
    sense_mode_e mode;

    // Remember the start bit to find its 0-to-1 change.
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= arm_i;
    end

    assign arm_rise = arm_i & ~arm_q;
    assign mode     = sense_mode_e'(sense_mode_i);

    req_line_sync #(
        .STAGES (SYNC_STAGES),
        .IDLE   (LINE_IDLE)
    ) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (ext_line_i),
        .line_s_o    (line_s),
        .line_prev_o (line_prev)
    );

    req_trigger_eval u_eval (
        .arm_i       (arm_i),
        .arm_rise_i  (arm_rise),
        .src_ext_i   (src_ext_i),
        .mode_i      (mode),
        .line_s_i    (line_s),
        .line_prev_i (line_prev),
        .trig_o      (trig)
    );

    req_pending u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (arm_i),
        .trig_i (trig),
        .ack_i  (ack_i),
        .pend_o (pend)
    );

    // Disarming masks the request in the same cycle.
    assign req_o = pend & arm_i;

endmodule

// File: rtl/dma_req_detect_chk.sv
// Module: dma_req_detect_chk
// Temporal checks on the request detector, bound into every instance.
// Assumes: the input rules stated in the brief's verification section.
module dma_req_detect_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       arm_i,
    input logic       src_ext_i,
    input logic [1:0] sense_mode_i,
    input logic       ack_i,
    input logic       req_o,
    input logic       line_s,
    input logic       line_prev
);
    logic arm_d;

    // Checker's own copy of the previous start bit.
    always_ff @(posedge clk) begin
        if (!rst_n) arm_d <= 1'b0;
        else        arm_d <= arm_i;
    end

    // R1: a software start raises the request one edge later.
    a_r1_soft_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_ext_i && arm_i && !arm_d) |=> (req_o || !arm_i));

    // R4: high-level sensing requests while the synchronised line is high.
    a_r4_level_high: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ext_i && sense_mode_i == 2'b01 && arm_i && line_s) |=> (req_o || !arm_i));

    // R5: a synchronised rising edge in rising-edge mode raises a request.
    a_r5_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ext_i && sense_mode_i == 2'b11 && arm_i && line_s && !line_prev)
        |=> (req_o || !arm_i));

    // R6: a disarmed cycle flushes anything pending.
    a_r6_disarm_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> !req_o);

    // R8: an unacknowledged request persists while armed.
    a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o || !arm_i));

endmodule

bind dma_req_detect dma_req_detect_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm_i        (arm_i),
    .src_ext_i    (src_ext_i),
    .sense_mode_i (sense_mode_i),
    .ack_i        (ack_i),
    .req_o        (req_o),
    .line_s       (line_s),
    .line_prev    (line_prev)
);

// File: tb/dma_req_detect_test.sv
// Directed bench for dma_req_detect: one task per scenario, inputs driven and
// outputs sampled on falling clock edges.
module dma_req_detect_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arm_i = 1'b0;
    logic       src_ext_i = 1'b0;
    logic [1:0] sense_mode_i = 2'b00;
    logic       ext_line_i = 1'b1;
    logic       ack_i = 1'b0;
    logic       req_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    dma_req_detect uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_i        (arm_i),
        .src_ext_i    (src_ext_i),
        .sense_mode_i (sense_mode_i),
        .ext_line_i   (ext_line_i),
        .ack_i        (ack_i),
        .req_o        (req_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic exp);
        checks++;
        if (req_o !== exp) begin
            failures++;
            $display("FAIL %s: req_o actual=%0b expected=%0b", tag, req_o, exp);
        end
    endtask

    task automatic pulse_ack();
        ack_i = 1'b1;
        step(1);
        ack_i = 1'b0;
    endtask

    task automatic t_reset();
        src_ext_i = 1'b1; sense_mode_i = 2'b11; ext_line_i = 1'b1;
        step(3);
        chk("R7 reset clears request", 1'b0);
        rst_n = 1'b1;
        arm_i = 1'b1;
        step(4);
        chk("R7 idle preload, no spurious edge", 1'b0);
        arm_i = 1'b0;
        step(1);
    endtask

    task automatic t_internal();
        src_ext_i = 1'b0; sense_mode_i = 2'b00;
        arm_i = 1'b1;
        step(1);
        chk("R1 soft start request", 1'b1);
        step(3);
        chk("R8 held until ack", 1'b1);
        pulse_ack();
        chk("R8 ack retires soft request", 1'b0);
        ext_line_i = 1'b0;
        step(4);
        chk("R9 line ignored in soft source", 1'b0);
        ext_line_i = 1'b1;
        step(3);
        arm_i = 1'b0;
        step(1);
        arm_i = 1'b1;
        step(1);
        chk("R1 second start", 1'b1);
        arm_i = 1'b0;
        #1;
        chk("R6 disarm drops request at once", 1'b0);
        step(1);
        chk("R6 stays cleared", 1'b0);
    endtask

    task automatic t_level_low();
        src_ext_i = 1'b1; sense_mode_i = 2'b00; ext_line_i = 1'b1;
        arm_i = 1'b1;
        step(4);
        chk("R4 low level idle line", 1'b0);
        ext_line_i = 1'b0;
        step(2);
        chk("R3 no request before third edge", 1'b0);
        step(1);
        chk("R3 R4 low level request", 1'b1);
        pulse_ack();
        chk("R4 re-raised while level persists", 1'b1);
        ext_line_i = 1'b1;
        step(3);
        chk("R8 held after level leaves", 1'b1);
        pulse_ack();
        chk("R4 ack with level gone", 1'b0);
        step(3);
        chk("R4 no request after level gone", 1'b0);
        arm_i = 1'b0;
        step(1);
    endtask

    task automatic t_level_high();
        src_ext_i = 1'b1; sense_mode_i = 2'b01; ext_line_i = 1'b1;
        arm_i = 1'b1;
        step(1);
        chk("R4 high level request", 1'b1);
        ext_line_i = 1'b0;
        step(3);
        pulse_ack();
        chk("R4 high level cleared", 1'b0);
        arm_i = 1'b0;
        ext_line_i = 1'b1;
        step(3);
    endtask

    task automatic t_edge_fall();
        src_ext_i = 1'b1; sense_mode_i = 2'b10; ext_line_i = 1'b1;
        arm_i = 1'b1;
        step(3);
        chk("R5 no edge no request", 1'b0);
        ext_line_i = 1'b0;
        step(2);
        chk("R3 edge not yet through", 1'b0);
        step(1);
        chk("R5 falling edge request", 1'b1);
        step(5);
        chk("R8 edge request held", 1'b1);
        pulse_ack();
        chk("R5 ack clears edge request", 1'b0);
        step(5);
        chk("R5 one request per edge", 1'b0);
        ext_line_i = 1'b1;
        step(4);
        chk("R5 opposite edge ignored", 1'b0);
        arm_i = 1'b0;
        step(1);
    endtask

    task automatic t_edge_rise();
        src_ext_i = 1'b1; sense_mode_i = 2'b11;
        arm_i = 1'b1;
        ext_line_i = 1'b0;
        step(2);
        ext_line_i = 1'b1;
        step(2);
        chk("R5 falling ignored in rise mode", 1'b0);
        step(1);
        chk("R5 rising edge request", 1'b1);
        pulse_ack();
        chk("R5 rise request acked", 1'b0);
        arm_i = 1'b0;
        step(1);
    endtask

    task automatic t_gated();
        src_ext_i = 1'b1; sense_mode_i = 2'b11; arm_i = 1'b0;
        ext_line_i = 1'b0;
        step(2);
        ext_line_i = 1'b1;
        step(5);
        chk("R2 edge while disarmed", 1'b0);
        arm_i = 1'b1;
        step(4);
        chk("R2 disarmed edge not remembered", 1'b0);
        arm_i = 1'b0;
        sense_mode_i = 2'b00;
        ext_line_i = 1'b0;
        step(5);
        chk("R2 level while disarmed", 1'b0);
        ext_line_i = 1'b1;
        step(3);
    endtask

    task automatic t_cancel();
        src_ext_i = 1'b1; sense_mode_i = 2'b10; ext_line_i = 1'b1;
        arm_i = 1'b1;
        step(1);
        ext_line_i = 1'b0;
        step(3);
        chk("R5 request before cancel", 1'b1);
        arm_i = 1'b0;
        #1;
        chk("R6 cancel same cycle", 1'b0);
        step(1);
        arm_i = 1'b1;
        step(4);
        chk("R6 cancelled request not resurrected", 1'b0);
        arm_i = 1'b0;
        ext_line_i = 1'b1;
        step(3);
    endtask

    initial begin
        t_reset();
        t_internal();
        t_level_low();
        t_level_high();
        t_edge_fall();
        t_edge_rise();
        t_gated();
        t_cancel();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule